// File: doc/BRIEF.md
# Gated Single-Scan Conversion Sequencer

This block walks one queue of conversion commands held in a local table and hands each command to an analog converter through a request/done handshake. A scan runs under two conditions at once: software has armed it by setting the scan-enable bit, and an external gate input is high. Every scan starts at table entry 0 and visits entries in increasing order. Each scan runs at most once per arming.

A scan can end in two ways. If it reaches an end-of-queue command, or finishes the last table entry, it raises the completion flag. If the gate has gone low by the time a conversion finishes, it raises the pause flag. In both cases the scan-enable bit clears itself. The gate is looked at only when a conversion finishes. A conversion that is already running always completes. A short low pulse on the gate between two conversion boundaries has no effect.

A pointer output holds the index of the most recent completed conversion, so software can see how far an interrupted scan got. The pause bit carried in a command word is ignored in this mode.

Top module: `gated_scan_seq`

## Requirements
- R1: After a synchronous reset, scan_en, done_flag, pause_flag and conv_req are 0, and last_ptr is 0.
- R2: A scan starts only when scan_en is 1, the synchronized gate is high and pause_flag is 0. While scan_en is 0 the gate level causes no request. A pulse on en_set while idle sets scan_en.
- R3: Each scan starts at table entry 0 and visits entries in increasing index order. conv_chan carries the channel field, which is bits [CHAN_W-1:0] of the command word.
- R4: Each visited non-end entry produces exactly one conversion. conv_req stays high with conv_chan stable until conv_done is seen, then drops.
- R5: A command whose channel field is all ones (63 for CHAN_W=6) is an end-of-queue mark. It issues no conversion, sets done_flag and clears scan_en.
- R6: When the conversion for entry DEPTH-1 finishes, the scan ends as complete: done_flag is set and scan_en is cleared.
- R7: The gate is sampled only in the cycle conv_done arrives. If it is low then, and the entry was not the last one, the scan stops, pause_flag is set and scan_en is cleared. Low pulses that have ended before that cycle do not stop the scan.
- R8: The pause bit, bit CHAN_W (bit 6) of a command word, has no effect: the scan neither stops nor sets pause_flag for it.
- R9: last_ptr changes only when a conversion finishes, and then takes that entry's index. A scan with no conversions leaves it unchanged.
- R10: A one-cycle pulse on clr_done clears done_flag, and a one-cycle pulse on clr_pause clears pause_flag.
- R11: After a scan ends, no further conversion is requested while the gate stays high, until scan_en is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_set | input | 1 | Pulse that arms a scan (sets scan_en while idle) |
| clr_done | input | 1 | Write-one-to-clear pulse for done_flag |
| clr_pause | input | 1 | Write-one-to-clear pulse for pause_flag |
| gate_in | input | 1 | External gate level, active high, asynchronous |
| tbl_we | input | 1 | Command table write strobe |
| tbl_waddr | input | IDX_W | Command table write index |
| tbl_wdata | input | CHAN_W+1 | Command word: pause bit on top, channel field below |
| conv_req | output | 1 | Conversion request, held until conv_done |
| conv_chan | output | CHAN_W | Channel of the requested conversion |
| conv_done | input | 1 | Converter reports the conversion finished |
| scan_en | output | 1 | Scan-enable bit |
| done_flag | output | 1 | Scan reached its end |
| pause_flag | output | 1 | Scan was cut short by the gate |
| last_ptr | output | IDX_W | Index of the last completed conversion |

## Verification
The bench builds the block with DEPTH=16, CHAN_W=6 and SYNC_STAGES=2. A table of 16 entries makes a scan that runs off the final entry short enough to repeat several times. It also lets random end-of-queue positions and gate drops cover the first entry, the middle and the last entry, including a gate drop on entry 15, where completion wins over pause. With two synchronizer stages the bench can hold a gate glitch exactly long enough to pass through the synchronizer and still clear before the conversion boundary.

// File: rtl/gss_pkg.sv
package gss_pkg;

  typedef enum logic [2:0] {
    S_IDLE      = 3'd0,
    S_FETCH     = 3'd1,
    S_CONVERT   = 3'd2,
    S_WAIT_DONE = 3'd3,
    S_COMPLETE  = 3'd4,
    S_PAUSED    = 3'd5
  } seq_state_t;

endpackage

// File: rtl/gss_gate_sync.sv
module gss_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];

endmodule

// File: rtl/gss_cmd_table.sv
module gss_cmd_table #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 7,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/gss_seq_fsm.sv
module gss_seq_fsm
  import gss_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CHAN_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CMD_W = CHAN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_set,
  input  logic              clr_done,
  input  logic              clr_pause,
  input  logic              gate_s,
  input  logic              conv_done,
  input  logic [CMD_W-1:0]  rd_word,
  output logic [IDX_W-1:0]  rd_addr,
  output logic              conv_req,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              scan_en,
  output logic              done_flag,
  output logic              pause_flag,
  output logic [IDX_W-1:0]  last_ptr
);

  localparam logic [CHAN_W-1:0] EOQ_CODE = '1;
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DEPTH - 1);

  seq_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic [CHAN_W-1:0] rd_chan;
  logic              rd_pause;
  logic              rd_eoq;

  assign rd_chan  = rd_word[CHAN_W-1:0];
  assign rd_pause = rd_word[CHAN_W];
  assign rd_eoq   = (rd_chan == EOQ_CODE);
  assign rd_addr  = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      idx        <= '0;
      scan_en    <= 1'b0;
      done_flag  <= 1'b0;
      pause_flag <= 1'b0;
      last_ptr   <= '0;
      conv_req   <= 1'b0;
      conv_chan  <= '0;
    end else begin
      if (clr_done)  done_flag  <= 1'b0;
      if (clr_pause) pause_flag <= 1'b0;
      case (state)
        S_IDLE: begin
          if (en_set) scan_en <= 1'b1;
          if (scan_en && gate_s && !pause_flag) begin
            idx   <= '0;
            state <= S_FETCH;
          end
        end
        S_FETCH: state <= S_CONVERT;
        S_CONVERT: begin
          if (rd_eoq) begin
            state <= S_COMPLETE;
          end else begin
            conv_req  <= 1'b1;
            conv_chan <= rd_chan;
            state     <= S_WAIT_DONE;
          end
        end
        S_WAIT_DONE: begin
          if (conv_done) begin
            conv_req <= 1'b0;
            last_ptr <= idx;
            if (idx == LAST_IDX) begin
              state <= S_COMPLETE;
            end else if (!gate_s) begin
              state <= S_PAUSED;
            end else begin
              idx   <= idx + IDX_W'(1);
              state <= S_FETCH;
            end
          end
        end
        S_COMPLETE: begin
          done_flag <= 1'b1;
          scan_en   <= 1'b0;
          state     <= S_IDLE;
        end
        S_PAUSED: begin
          pause_flag <= 1'b1;
          scan_en    <= 1'b0;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4: request held with a stable channel until the converter answers
  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_done) |=> (conv_req && $stable(conv_chan)));

  // R2: no conversion is requested unless the scan is armed
  a_r2_req_needs_en: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> scan_en);

  // R9: the pointer only moves after a finished conversion
  a_r9_ptr_on_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(last_ptr) |-> $past(conv_done));

  // R5: completion disarms the scan in the same cycle
  a_r5_done_disarms: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> !scan_en);

  // R7: a pause follows a finished conversion that saw the gate low
  a_r7_pause_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(pause_flag) |-> (!scan_en && $past(conv_done, 2) && !$past(gate_s, 2)));

  // R8: a command carrying the pause bit still converts
  a_r8_pause_bit_ignored: assert property (@(posedge clk) disable iff (rst)
    (state == S_CONVERT && rd_pause && !rd_eoq) |=> conv_req);

endmodule

// File: rtl/gated_scan_seq.sv
module gated_scan_seq #(
  parameter int DEPTH       = 64,
  parameter int CHAN_W      = 6,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int CMD_W      = CHAN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_set,
  input  logic              clr_done,
  input  logic              clr_pause,
  input  logic              gate_in,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_waddr,
  input  logic [CMD_W-1:0]  tbl_wdata,
  output logic              conv_req,
  output logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_done,
  output logic              scan_en,
  output logic              done_flag,
  output logic              pause_flag,
  output logic [IDX_W-1:0]  last_ptr
);

  logic             gate_s;
  logic [IDX_W-1:0] rd_addr;
  logic [CMD_W-1:0] rd_word;

  gss_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (gate_in),
    .q   (gate_s)
  );

  gss_cmd_table #(.DEPTH(DEPTH), .WIDTH(CMD_W)) u_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  gss_seq_fsm #(.DEPTH(DEPTH), .CHAN_W(CHAN_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en_set     (en_set),
    .clr_done   (clr_done),
    .clr_pause  (clr_pause),
    .gate_s     (gate_s),
    .conv_done  (conv_done),
    .rd_word    (rd_word),
    .rd_addr    (rd_addr),
    .conv_req   (conv_req),
    .conv_chan  (conv_chan),
    .scan_en    (scan_en),
    .done_flag  (done_flag),
    .pause_flag (pause_flag),
    .last_ptr   (last_ptr)
  );

endmodule

// File: tb/sim_gated_scan_seq.sv
module sim_gated_scan_seq;
  localparam int DEPTH  = 16;
  localparam int CHAN_W = 6;
  localparam int SYNC   = 2;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CMD_W  = CHAN_W + 1;
  localparam logic [CHAN_W-1:0] EOQ = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_set = 0, clr_done = 0, clr_pause = 0, gate_in = 0;
  logic tbl_we = 0;
  logic [IDX_W-1:0] tbl_waddr = '0;
  logic [CMD_W-1:0] tbl_wdata = '0;
  logic conv_done = 0;
  logic conv_req, scan_en, done_flag, pause_flag;
  logic [CHAN_W-1:0] conv_chan;
  logic [IDX_W-1:0] last_ptr;

  int n_chk = 0, n_bad = 0;
  int prev_last = 0;
  logic [CMD_W-1:0] tb_tbl [DEPTH];

  always #5 clk = ~clk;

  gated_scan_seq #(.DEPTH(DEPTH), .CHAN_W(CHAN_W), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .en_set(en_set), .clr_done(clr_done),
    .clr_pause(clr_pause), .gate_in(gate_in), .tbl_we(tbl_we),
    .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_done(conv_done), .scan_en(scan_en),
    .done_flag(done_flag), .pause_flag(pause_flag), .last_ptr(last_ptr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_entry(input int i, input logic [CMD_W-1:0] w);
    @(negedge clk);
    tbl_we = 1; tbl_waddr = IDX_W'(i); tbl_wdata = w; tb_tbl[i] = w;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic pulse_en();
    @(negedge clk); en_set = 1; @(negedge clk); en_set = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_done = 1; clr_pause = 1;
    @(negedge clk); clr_done = 0; clr_pause = 0;
  endtask

  function automatic int exp_len();
    for (int i = 0; i < DEPTH; i++)
      if (tb_tbl[i][CHAN_W-1:0] == EOQ) return i;
    return DEPTH;
  endfunction

  // Converter model: answers each request, optionally disturbing the gate
  task automatic serve(input int drop_at, input int glitch_at, output int n);
    n = 0;
    forever begin
      int waitc = 0;
      int lat;
      while (!conv_req && scan_en && waitc < 300) begin
        @(negedge clk); waitc++;
      end
      if (!conv_req) break;
      chk("R3 channel order", int'(conv_chan), int'(tb_tbl[n][CHAN_W-1:0]));
      lat = 1 + int'($urandom_range(3));
      if (n == glitch_at) begin
        gate_in = 0; @(negedge clk); gate_in = 1; lat += 4;
      end
      if (n == drop_at) begin
        gate_in = 0; lat += 4;
      end
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk("R4 request held", int'(conv_req), 1);
      end
      conv_done = 1;
      @(negedge clk);
      conv_done = 0;
      n++;
    end
  endtask

  task automatic end_check(input string tag, input int n, input int n_exp,
                           input bit exp_done, input bit exp_pause);
    int exp_last;
    exp_last = (n_exp > 0) ? n_exp - 1 : prev_last;
    chk({tag, " conversion count"}, n, n_exp);
    chk({tag, " done_flag"}, int'(done_flag), int'(exp_done));
    chk({tag, " pause_flag"}, int'(pause_flag), int'(exp_pause));
    chk({tag, " scan_en cleared"}, int'(scan_en), 0);
    chk("R9 last_ptr", int'(last_ptr), exp_last);
    prev_last = exp_last;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 scan_en", int'(scan_en), 0);
    chk("R1 done_flag", int'(done_flag), 0);
    chk("R1 pause_flag", int'(pause_flag), 0);
    chk("R1 conv_req", int'(conv_req), 0);
    chk("R1 last_ptr", int'(last_ptr), 0);

    // Table: 0..4 with pause bit on entry 2, end mark at 5
    for (int i = 0; i < DEPTH; i++)
      put_entry(i, (i == 5) ? {1'b0, EOQ} : {(i == 2), CHAN_W'(i + 10)});

    // R2: gate high but not armed
    gate_in = 1;
    repeat (12) @(negedge clk);
    chk("R2 gate ignored while disarmed", int'(conv_req), 0);
    // R2: armed but gate low
    gate_in = 0;
    pulse_en();
    repeat (12) @(negedge clk);
    chk("R2 armed scan_en", int'(scan_en), 1);
    chk("R2 no request with gate low", int'(conv_req), 0);
    // R5/R8: run to the end mark through the pause-bit entry
    gate_in = 1;
    serve(-1, -1, n);
    end_check("R5 R8", n, 5, 1, 0);
    // R11: gate held high, no rerun
    repeat (20) @(negedge clk);
    chk("R11 no second scan", int'(conv_req), 0);
    // R10 clear done
    @(negedge clk); clr_done = 1; @(negedge clk); clr_done = 0;
    chk("R10 clr_done", int'(done_flag), 0);

    // R6: no end mark, run off the last entry
    put_entry(5, {1'b1, CHAN_W'(3)});
    pulse_en();
    serve(-1, -1, n);
    end_check("R6", n, DEPTH, 1, 0);
    clear_flags();

    // R7: gate closes during entry 3
    pulse_en();
    serve(3, -1, n);
    end_check("R7 early close", n, 4, 0, 1);
    gate_in = 1;
    // R2: pause flag still set blocks the next scan
    pulse_en();
    repeat (20) @(negedge clk);
    chk("R2 blocked by pause_flag", int'(conv_req), 0);
    @(negedge clk); clr_pause = 1; @(negedge clk); clr_pause = 0;
    chk("R10 clr_pause", int'(pause_flag), 0);
    // R3: restart from entry 0 (serve checks each channel)
    serve(-1, -1, n);
    end_check("R3 restart", n, DEPTH, 1, 0);
    clear_flags();

    // R7: short glitch between boundaries is missed
    pulse_en();
    serve(-1, 1, n);
    end_check("R7 glitch", n, DEPTH, 1, 0);
    clear_flags();

    // R5/R9: end mark at entry 0
    put_entry(0, {1'b0, EOQ});
    pulse_en();
    serve(-1, -1, n);
    end_check("R5 empty", n, 0, 1, 0);
    clear_flags();

    // Random tables, end marks and gate drops
    for (int t = 0; t < 12; t++) begin
      int eoq_at, drop, len, n_exp;
      bit paused;
      eoq_at = int'($urandom_range(DEPTH));
      drop = ($urandom_range(2) == 0) ? int'($urandom_range(DEPTH - 1)) : -1;
      if (t == 0) begin eoq_at = DEPTH; drop = DEPTH - 1; end
      for (int i = 0; i < DEPTH; i++)
        put_entry(i, (i == eoq_at) ? {1'($urandom_range(1)), EOQ}
                                   : {1'($urandom_range(1)), CHAN_W'($urandom_range(62))});
      len = exp_len();
      paused = (drop >= 0) && (drop < len) && (drop != DEPTH - 1);
      n_exp = paused ? drop + 1 : len;
      gate_in = 1;
      pulse_en();
      serve(drop, -1, n);
      end_check(paused ? "R7 random" : "R6 random", n, n_exp, !paused, paused);
      gate_in = 1;
      clear_flags();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule